// File: doc/BRIEF.md
# Operand Shift and Rotate Unit

This block is the shift stage of a 32-bit integer datapath. It takes one operand and moves its bits left or right by a computed distance. It supports five operations: arithmetic right shift, logical left shift, logical right shift, rotate right, and a one-position rotate right that passes through the carry flag. The distance comes from one of two sources. The first is a small immediate field. The second is the lowest byte of a second register value, which allows any distance from 0 to 255. The result and the carry-out are produced combinationally in the same cycle as the inputs. The input operand is only read and is never changed.

Three condition flags sit next to the shifter: negative, zero and carry. On a clock edge where the update control is high, they are loaded from the current result and carry-out. On every other edge they keep their value. The stored carry also feeds back into the shifter. It is used as the carry-out when the distance is zero, and as the bit rotated into the top position by the through-carry rotate. Operand fetch, instruction decoding, condition tests and overflow are handled outside this block.

Top module: `bshift_core`

## Requirements
- R1: `op_sel` encodes the operation as 0 = arithmetic right shift, 1 = logical left shift, 2 = logical right shift, 3 = rotate right, 4 = rotate right through carry. Codes 5 to 7 give `result` equal to `operand` and `carry_out` equal to the stored carry flag.
- R2: When `amt_from_reg` is 1, the distance is `reg_amt[7:0]` (0 to 255) and `reg_amt[31:8]` has no effect. When it is 0, the distance is `imm_amt` (0 to 63) and `reg_amt` has no effect.
- R3: For any operation other than code 4, a distance of 0 gives `result` equal to `operand` and `carry_out` equal to the stored carry flag.
- R4: Logical left shift by d in 1..31 gives `operand << d` with carry `operand[32-d]`. By exactly 32 it gives zero with carry `operand[0]`. Beyond 32 it gives zero with carry 0.
- R5: Logical right shift by d in 1..31 gives `operand >> d` with carry `operand[d-1]`. By exactly 32 it gives zero with carry `operand[31]`. Beyond 32 it gives zero with carry 0.
- R6: Arithmetic right shift by d in 1..31 fills the vacated bits with `operand[31]` and gives carry `operand[d-1]`. For d of 32 or more, every result bit and the carry equal `operand[31]`.
- R7: Rotate right by a nonzero d rotates by d modulo 32, and the carry equals result bit 31. A nonzero multiple of 32 therefore returns `operand` with carry `operand[31]`.
- R8: Code 4 ignores the distance. It gives `{stored carry, operand[31:1]}` with carry `operand[0]`.
- R9: On a rising edge with `flag_upd` high, `flag_c` takes `carry_out`, `flag_n` takes `result[31]`, and `flag_z` takes 1 exactly when `result` is zero. With `flag_upd` low, all three flags hold.
- R10: A rising edge with `rst_n` low clears all three flags to 0, regardless of `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op_sel | input | 3 | Operation code |
| amt_from_reg | input | 1 | 1 selects the register byte as the distance, 0 selects the immediate |
| imm_amt | input | 6 | Immediate shift distance |
| reg_amt | input | 32 | Register operand whose low byte supplies the distance |
| operand | input | 32 | Value to be shifted |
| flag_upd | input | 1 | Loads the flags at the next rising edge |
| result | output | 32 | Shifted value, combinational |
| carry_out | output | 1 | Bit shifted out, combinational |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag, also used as carry-in |

## Verification
`result` and `carry_out` are due in the same cycle as their inputs, because no register lies between them and the inputs. The bench changes the inputs on a falling clock edge and compares the outputs 1 ns later, well before the next rising edge, with flag update held low so the carry-in cannot move. A flag update happens at the rising edge that follows. Flag values are therefore read at the next falling edge, one full register stage after the stimulus.

// File: rtl/bshift_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes and distance classification for the shift unit.
// Assumes: the operation field is three bits wide; codes above 4 are treated as pass-through.
package bshift_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        SH_ASR = 3'd0,
        SH_LSL = 3'd1,
        SH_LSR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shop_e;

    // Coarse position of the effective distance relative to the data width.
    typedef struct packed {
        logic zero;   // distance is 0
        logic below;  // distance is less than the data width
        logic equal;  // distance equals the data width
    } amt_class_t;
endpackage

// File: rtl/bshift_amount.sv
`timescale 1ns/1ps
// Module: chooses the effective shift distance and classifies it against the width.
// Assumes: IMM_W <= AMT_W, and WIDTH fits in AMT_W bits.
module bshift_amount
    import bshift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 6
) (
    input  logic             use_reg,
    input  logic [IMM_W-1:0] imm_val,
    input  logic [AMT_W-1:0] reg_low,
    output logic [AMT_W-1:0] amt,
    output amt_class_t       cls
);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

    // Pick the distance source; the immediate is zero-extended.
    always_comb begin
        amt = use_reg ? reg_low : AMT_W'(imm_val);
    end

    // Classify the distance for the edge-case selection in the datapath.
    always_comb begin
        cls.zero  = (amt == '0);
        cls.below = (amt < W_AMT);
        cls.equal = (amt == W_AMT);
    end
endmodule

// File: rtl/bshift_stages.sv
`timescale 1ns/1ps
// Module: logarithmic shifter built from SB conditional power-of-two stages.
// KIND 0 shifts left inserting fill, KIND 1 shifts right inserting fill,
// KIND 2 rotates right. Assumes 2**(SB-1) < DW.
module bshift_stages #(
    parameter int DW   = 33,
    parameter int SB   = 5,
    parameter int KIND = 0
) (
    input  logic [DW-1:0] din,
    input  logic [SB-1:0] amt,
    input  logic          fill,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] lvl [SB+1];

    assign lvl[0] = din;

    genvar s;
    generate
        for (s = 0; s < SB; s++) begin : g_stage
            localparam int STEP = 1 << s;
            if (KIND == 0) begin : g_left
                // Move left by STEP when this distance bit is set.
                assign lvl[s+1] = amt[s] ? {lvl[s][DW-1-STEP:0], {STEP{fill}}} : lvl[s];
            end else if (KIND == 1) begin : g_right
                // Move right by STEP, filling the top with the fill bit.
                assign lvl[s+1] = amt[s] ? {{STEP{fill}}, lvl[s][DW-1:STEP]} : lvl[s];
            end else begin : g_rot
                // Rotate right by STEP; the low bits wrap to the top.
                assign lvl[s+1] = amt[s] ? {lvl[s][STEP-1:0], lvl[s][DW-1:STEP]} : lvl[s];
            end
        end
        if (KIND == 2) begin : g_fill_sink
            logic unused_fill;
            assign unused_fill = fill;
        end
    endgenerate

    assign dout = lvl[SB];
endmodule

// File: rtl/bshift_datapath.sv
`timescale 1ns/1ps
// Module: combinational result and carry-out for all five operations.
// Assumes: WIDTH is a power of two, so rotate distance modulo WIDTH is the low SB bits.
module bshift_datapath
    import bshift_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  shop_e                       op,
    input  logic [WIDTH-1:0]            x,
    input  logic [$clog2(WIDTH)-1:0]    low_amt,
    input  amt_class_t                  cls,
    input  logic                        cin,
    output logic [WIDTH-1:0]            res,
    output logic                        cout
);
    localparam int SB = $clog2(WIDTH);
    localparam int EW = WIDTH + 1;

    logic [EW-1:0]    left_ext;
    logic [EW-1:0]    right_ext;
    logic [WIDTH-1:0] rot_val;
    logic             right_fill;
    logic             sign;

    assign sign       = x[WIDTH-1];
    assign right_fill = (op == SH_ASR) & sign;

    // Left chain: an extra top bit catches the last bit shifted out.
    bshift_stages #(.DW(EW), .SB(SB), .KIND(0)) u_left (
        .din (EW'({1'b0, x})),
        .amt (low_amt),
        .fill(1'b0),
        .dout(left_ext)
    );

    // Right chain: an extra bottom bit catches the last bit shifted out.
    bshift_stages #(.DW(EW), .SB(SB), .KIND(1)) u_right (
        .din ({x, 1'b0}),
        .amt (low_amt),
        .fill(right_fill),
        .dout(right_ext)
    );

    // Rotate chain over the plain operand.
    bshift_stages #(.DW(WIDTH), .SB(SB), .KIND(2)) u_rot (
        .din (x),
        .amt (low_amt),
        .fill(1'b0),
        .dout(rot_val)
    );

    // Select the result and carry for the operation and distance class.
    always_comb begin
        res  = x;
        cout = cin;
        if (op == SH_RRX) begin
            res  = {cin, x[WIDTH-1:1]};
            cout = x[0];
        end else if (!cls.zero) begin
            unique case (op)
                SH_LSL: begin
                    if (cls.below) begin
                        res  = left_ext[WIDTH-1:0];
                        cout = left_ext[WIDTH];
                    end else begin
                        res  = '0;
                        cout = cls.equal & x[0];
                    end
                end
                SH_LSR: begin
                    if (cls.below) begin
                        res  = right_ext[EW-1:1];
                        cout = right_ext[0];
                    end else begin
                        res  = '0;
                        cout = cls.equal & sign;
                    end
                end
                SH_ASR: begin
                    if (cls.below) begin
                        res  = right_ext[EW-1:1];
                        cout = right_ext[0];
                    end else begin
                        res  = {WIDTH{sign}};
                        cout = sign;
                    end
                end
                SH_ROR: begin
                    res  = rot_val;
                    cout = rot_val[WIDTH-1];
                end
                default: begin
                    res  = x;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/bshift_flags.sv
`timescale 1ns/1ps
// Module: negative, zero and carry flag registers loaded under an update control.
// Assumes: synchronous active-low reset that takes priority over the update.
module bshift_flags #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [WIDTH-1:0] res_in,
    input  logic             carry_in,
    output logic             n_q,
    output logic             z_q,
    output logic             c_q
);
    // Clear on reset, load from the current result on update, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (upd) begin
            n_q <= res_in[WIDTH-1];
            z_q <= (res_in == '0);
            c_q <= carry_in;
        end
    end
endmodule

// File: rtl/bshift_core.sv
`timescale 1ns/1ps
// Module: top of the shift unit: distance select, shift datapath and flags.
// Assumes: WIDTH is a power of two; the carry-in is the stored carry flag.
module bshift_core
    import bshift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op_sel,
    input  logic                 amt_from_reg,
    input  logic [IMM_W-1:0]     imm_amt,
    input  logic [WIDTH-1:0]     reg_amt,
    input  logic [WIDTH-1:0]     operand,
    input  logic                 flag_upd,
    output logic [WIDTH-1:0]     result,
    output logic                 carry_out,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_c
);
    localparam int SB = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

    shop_e            op;
    logic [AMT_W-1:0] amt;
    amt_class_t       cls;
    logic             unused_amt_hi;

    assign op            = shop_e'(op_sel);
    assign unused_amt_hi = ^reg_amt[WIDTH-1:AMT_W];

    bshift_amount #(.WIDTH(WIDTH), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_amount (
        .use_reg(amt_from_reg),
        .imm_val(imm_amt),
        .reg_low(reg_amt[AMT_W-1:0]),
        .amt    (amt),
        .cls    (cls)
    );

    bshift_datapath #(.WIDTH(WIDTH)) u_path (
        .op     (op),
        .x      (operand),
        .low_amt(amt[SB-1:0]),
        .cls    (cls),
        .cin    (flag_c),
        .res    (result),
        .cout   (carry_out)
    );

    bshift_flags #(.WIDTH(WIDTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (flag_upd),
        .res_in  (result),
        .carry_in(carry_out),
        .n_q     (flag_n),
        .z_q     (flag_z),
        .c_q     (flag_c)
    );

    AST_UNKNOWN_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |-> (result == operand && carry_out == flag_c)); // R1
    AST_ZERO_DIST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 3'd4 && amt == '0) |-> (result == operand && carry_out == flag_c)); // R3
    AST_LOGICAL_FAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 3'd1 || op_sel == 3'd2) && amt > W_AMT) |-> (result == '0 && !carry_out)); // R4
    AST_LSR_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && amt == W_AMT) |-> (result == '0 && carry_out == operand[WIDTH-1])); // R5
    AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && amt >= W_AMT) |-> (result == {WIDTH{operand[WIDTH-1]}} && carry_out == operand[WIDTH-1])); // R6
    AST_ROR_WRAP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 && amt != '0 && amt[SB-1:0] == '0) |-> (result == operand && carry_out == operand[WIDTH-1])); // R7
    AST_RRX_THROUGH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4) |-> (result == {flag_c, operand[WIDTH-1:1]} && carry_out == operand[0])); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd |=> $stable({flag_n, flag_z, flag_c})); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c} == 3'b000)); // R10
endmodule

// File: tb/bshift_core_test.sv
`timescale 1ns/1ps
module bshift_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_sel;
    logic        amt_from_reg;
    logic [5:0]  imm_amt;
    logic [31:0] reg_amt;
    logic [31:0] operand;
    logic        flag_upd;
    logic [31:0] result;
    logic        carry_out;
    logic        flag_n, flag_z, flag_c;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic exp_n = 1'b0, exp_z = 1'b0, exp_c = 1'b0;

    always #4 clk = ~clk;

    bshift_core uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .amt_from_reg(amt_from_reg),
        .imm_amt(imm_amt), .reg_amt(reg_amt), .operand(operand), .flag_upd(flag_upd),
        .result(result), .carry_out(carry_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic check(string req, string what, logic [32:0] act, logic [32:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Arithmetic reference: {carry, result}.
    function automatic logic [32:0] model(int op, int a, logic [31:0] x, logic cin);
        logic [63:0]        t;
        logic signed [63:0] ts;
        logic [31:0]        r;
        int                 m;
        if (op == 4) return {x[0], cin, x[31:1]};
        if (op > 4 || a == 0) return {cin, x};
        case (op)
            1: begin
                t = {32'b0, x} << a;
                return {t[32], t[31:0]};
            end
            2: begin
                if (a > 32) return 33'b0;
                t = {x, 32'b0} >> a;
                return {t[31], t[63:32]};
            end
            0: begin
                if (a >= 32) return {x[31], {32{x[31]}}};
                ts = $signed({x, 32'b0}) >>> a;
                return {ts[31], ts[63:32]};
            end
            default: begin
                m = a % 32;
                if (m == 0) return {x[31], x};
                r = (x >> m) | (x << (32 - m));
                return {r[31], r};
            end
        endcase
    endfunction

    function automatic string req_of(int op, int a);
        if (op > 4)  return "R1";
        if (op == 4) return "R8";
        if (a == 0)  return "R3";
        case (op)
            0: return "R6";
            1: return "R4";
            2: return "R5";
            default: return "R7";
        endcase
    endfunction

    // One clocked step in register mode; checks the stored flags afterwards.
    task automatic flag_step(int op, int a, logic [31:0] x, logic upd);
        logic [32:0] e;
        @(negedge clk);
        op_sel = 3'(op); amt_from_reg = 1'b1; reg_amt = 32'(a); operand = x; flag_upd = upd;
        e = model(op, a, x, exp_c);
        @(negedge clk);
        flag_upd = 1'b0;
        if (upd) begin
            exp_c = e[32]; exp_n = e[31]; exp_z = (e[31:0] == 32'b0);
        end
        check("R9", "flags", 33'({flag_n, flag_z, flag_c}), 33'({exp_n, exp_z, exp_c}));
    endtask

    initial begin
        logic [31:0] pats [6];
        logic [32:0] e;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
        pats[3] = 32'h7FFF_FFFE; pats[4] = 32'hA5C3_0F96; pats[5] = 32'h0000_0001;

        rst_n = 1'b0; op_sel = 3'd1; amt_from_reg = 1'b1; imm_amt = 6'd0;
        reg_amt = 32'd32; operand = 32'h8000_0001; flag_upd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears flags even with update requested
        check("R10", "flags in reset", 33'({flag_n, flag_z, flag_c}), 33'b0);
        flag_upd = 1'b0; rst_n = 1'b1;

        // R9: update and hold behaviour across several results
        flag_step(1, 32, 32'h8000_0001, 1'b1);
        flag_step(2, 1, 32'h8000_0000, 1'b1);
        flag_step(0, 4, 32'h8000_0000, 1'b1);
        flag_step(1, 40, 32'hFFFF_FFFF, 1'b0);
        flag_step(3, 1, 32'h0000_0001, 1'b1);
        flag_step(2, 33, 32'h1234_5678, 1'b0);

        // Register-distance sweep over every byte value, junk in upper bits (R2)
        for (int cv = 0; cv < 2; cv++) begin
            flag_step(4, 0, {31'b0, 1'(cv)}, 1'b1);
            for (int p = 0; p < 6; p++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int a = 0; a < 256; a++) begin
                        @(negedge clk);
                        op_sel = 3'(op); amt_from_reg = 1'b1; operand = pats[p];
                        reg_amt = {24'hA5C3F0 ^ 24'(a * 7 + p), 8'(a)};
                        imm_amt = 6'(a + 13);
                        #1;
                        e = model(op, a, pats[p], exp_c);
                        check(req_of(op, a), "reg dist", {carry_out, result}, e);
                        if (a == 200 && op == 2) check("R2", "upper bits ignored", {carry_out, result}, e);
                    end
                end
            end
        end

        // Immediate-distance sweep, register value differs to show it is ignored (R2)
        for (int cv = 0; cv < 2; cv++) begin
            flag_step(4, 0, {31'b0, 1'(cv)}, 1'b1);
            for (int p = 0; p < 6; p++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int a = 0; a < 64; a++) begin
                        @(negedge clk);
                        op_sel = 3'(op); amt_from_reg = 1'b0; operand = pats[p];
                        imm_amt = 6'(a); reg_amt = 32'h0000_0005;
                        #1;
                        e = model(op, a, pats[p], exp_c);
                        check(req_of(op, a), "imm dist", {carry_out, result}, e);
                        if (a == 0 && op == 1) check("R2", "reg ignored in imm mode", {carry_out, result}, e);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule